// File: doc/BRIEF.md
# NOR Toggle-Bit Completion Poller

This block decides when an embedded program or erase operation inside a parallel NOR flash has finished. Once started with a target address and a cycle budget, it reads that address twice in a row and compares the toggle status bit (data bit 6) of the two words. While the flash is busy this bit flips on every read. Once the bit holds still, the operation is complete.

The first word of each pair also carries a fault flag (data bit 5), which the flash raises when its internal time limit has been exceeded. When the flag is set and the pair still toggles, the poller takes one more pair before reaching a verdict. The bit may simply have stopped between the two pairs, which counts as success. Otherwise the operation has failed.

A cycle budget bounds the whole poll. The poller has one read port, which holds each request until the bus engine returns data. Its result is a two-bit code with a one-cycle valid pulse. Recovering the flash after a failure is left to the caller.

Top module: `nor_busy_poller`

## Requirements
- R1: After reset, readReq and resultValid are low.
- R2: Every read of a poll is issued at the start address. readReq stays high with a stable readAddr until readValid returns, and the two reads of a pair are issued back to back.
- R3: When bit 6 (mask 0x0040) is equal in both words of a pair, the poll ends with resultCode 2'b01 (success).
- R4: When the words of a pair differ in bit 6 and bit 5 (mask 0x0020) of the first word is set, exactly one further pair is read. Equal bit 6 in that pair gives success.
- R5: When that further pair still differs in bit 6, the poll ends with resultCode 2'b10 (error) after exactly four reads for that check.
- R6: When a pair differs in bit 6 and bit 5 of its first word is clear, the poller starts another check.
- R7: Before each check, the poll ends with resultCode 2'b11 (timeout) if the number of clock cycles since the request has reached startLimit. A startLimit of 0 gives timeout with no read at all.
- R8: A startLimit of all ones disables the timeout, so a long poll still ends in success.
- R9: resultValid is high for exactly one cycle per accepted request, and resultCode is never 2'b00 while it is high.
- R10: startReq is ignored while a poll is in progress. The address, the budget and the outcome of the running poll are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a poll (accepted only when idle) |
| startAddr | input | AW | Flash address to poll |
| startLimit | input | TW | Cycle budget; all ones disables the timeout |
| readReq | output | 1 | Read request to the bus engine, held until served |
| readAddr | output | AW | Address of the requested read |
| readValid | input | 1 | Read data valid, one cycle |
| readData | input | DW | Word returned by the flash |
| resultValid | output | 1 | One-cycle pulse marking a result |
| resultCode | output | 2 | 01 success, 10 error, 11 timeout |

## Verification
The checker watches the read handshake on every cycle. It confirms that a request is held with a steady address until data returns. It also confirms that no read is requested while a result is shown, and that each result pulse lasts one cycle with a non-zero code.

Some behaviour only the bench scenarios can show. These cover the outcome of a poll and how many reads it took: toggle runs of different lengths, a fault flag that rises before or after the bit settles, a zero budget, a short budget, and the unlimited budget. They also include a start request raised in the middle of a poll.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_OK   = 2'b01,
    RES_ERR  = 2'b10,
    RES_TMO  = 2'b11
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_A,
    ST_RD_B,
    ST_EVAL,
    ST_DONE
  } poll_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch address and budget, clear cycle counter
    logic capFirst;   // capture first word of a pair
    logic capSecond;  // capture second word of a pair
    logic tick;       // advance the cycle counter
  } dp_ctrl_t;

endpackage

// File: rtl/nor_poll_dp.sv
module nor_poll_dp
  import nor_poll_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int TW         = 16,
  parameter int TOGGLE_BIT = 6,
  parameter int FAULT_BIT  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dp_ctrl_t      ctl,
  input  logic [AW-1:0] startAddr,
  input  logic [TW-1:0] startLimit,
  input  logic [DW-1:0] readData,
  output logic [AW-1:0] pollAddr,
  output logic          limitHit,
  output logic          bitSame,
  output logic          faultSeen
);
  localparam logic [DW-1:0] TOGGLE_MASK = DW'(1) << TOGGLE_BIT;
  localparam logic [DW-1:0] FAULT_MASK  = DW'(1) << FAULT_BIT;
  localparam logic [TW-1:0] NO_LIMIT    = '1;

  logic [TW-1:0] limitReg;
  logic [TW-1:0] cycleCnt;
  logic [DW-1:0] firstWord;
  logic [DW-1:0] secondWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pollAddr   <= '0;
      limitReg   <= '0;
      cycleCnt   <= '0;
      firstWord  <= '0;
      secondWord <= '0;
    end else begin
      if (ctl.load) begin
        pollAddr <= startAddr;
        limitReg <= startLimit;
        cycleCnt <= '0;
      end else if (ctl.tick && cycleCnt != '1) begin
        cycleCnt <= cycleCnt + 1'b1;
      end
      if (ctl.capFirst)  firstWord  <= readData;
      if (ctl.capSecond) secondWord <= readData;
    end
  end

  assign limitHit  = (limitReg != NO_LIMIT) && (cycleCnt >= limitReg);
  assign bitSame   = ~|((firstWord ^ secondWord) & TOGGLE_MASK);
  assign faultSeen = |(firstWord & FAULT_MASK);

endmodule

// File: rtl/nor_poll_ctrl.sv
module nor_poll_ctrl
  import nor_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       readValid,
  input  logic       limitHit,
  input  logic       bitSame,
  input  logic       faultSeen,
  output dp_ctrl_t   ctl,
  output logic       readReq,
  output logic       resultValid,
  output logic [1:0] resultCode
);
  poll_state_e state;
  logic        retryPair;
  result_e     result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      retryPair <= 1'b0;
      result    <= RES_NONE;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state     <= ST_CHECK;
          retryPair <= 1'b0;
        end
        ST_CHECK: begin
          if (limitHit) begin
            result <= RES_TMO;
            state  <= ST_DONE;
          end else begin
            state <= ST_RD_A;
          end
        end
        ST_RD_A: if (readValid) state <= ST_RD_B;
        ST_RD_B: if (readValid) state <= ST_EVAL;
        ST_EVAL: begin
          if (bitSame) begin
            result <= RES_OK;
            state  <= ST_DONE;
          end else if (retryPair) begin
            result <= RES_ERR;
            state  <= ST_DONE;
          end else if (faultSeen) begin
            retryPair <= 1'b1;
            state     <= ST_RD_A;
          end else begin
            state <= ST_CHECK;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && startReq;
    ctl.capFirst  = (state == ST_RD_A) && readValid;
    ctl.capSecond = (state == ST_RD_B) && readValid;
    ctl.tick      = (state != ST_IDLE);
  end

  assign readReq     = (state == ST_RD_A) || (state == ST_RD_B);
  assign resultValid = (state == ST_DONE);
  assign resultCode  = (state == ST_DONE) ? result : RES_NONE;

endmodule

// File: rtl/nor_busy_poller.sv
module nor_busy_poller
  import nor_poll_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startReq,
  input  logic [AW-1:0] startAddr,
  input  logic [TW-1:0] startLimit,
  output logic          readReq,
  output logic [AW-1:0] readAddr,
  input  logic          readValid,
  input  logic [DW-1:0] readData,
  output logic          resultValid,
  output logic [1:0]    resultCode
);
  dp_ctrl_t ctl;
  logic     limitHit;
  logic     bitSame;
  logic     faultSeen;

  nor_poll_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .startReq    (startReq),
    .readValid   (readValid),
    .limitHit    (limitHit),
    .bitSame     (bitSame),
    .faultSeen   (faultSeen),
    .ctl         (ctl),
    .readReq     (readReq),
    .resultValid (resultValid),
    .resultCode  (resultCode)
  );

  nor_poll_dp #(.AW(AW), .DW(DW), .TW(TW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .startAddr  (startAddr),
    .startLimit (startLimit),
    .readData   (readData),
    .pollAddr   (readAddr),
    .limitHit   (limitHit),
    .bitSame    (bitSame),
    .faultSeen  (faultSeen)
  );

endmodule

// File: rtl/nor_busy_poller_chk.sv
module nor_busy_poller_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          readReq,
  input logic          readValid,
  input logic [AW-1:0] readAddr,
  input logic          resultValid,
  input logic [1:0]    resultCode
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readReq && !readValid |=> readReq);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readReq && $past(readReq) |-> readAddr == $past(readAddr));

  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R9
  result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> resultCode != 2'b00);

  // R2
  no_read_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> !readReq);

endmodule

bind nor_busy_poller nor_busy_poller_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .readReq     (readReq),
  .readValid   (readValid),
  .readAddr    (readAddr),
  .resultValid (resultValid),
  .resultCode  (resultCode)
);

// File: tb/nor_busy_poller_tb.sv
module nor_busy_poller_tb;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 16;

  typedef struct packed {
    logic [15:0] toggles;   // reads that still toggle bit 6
    logic [15:0] faultAt;   // read index from which bit 5 is set
    logic [15:0] limit;
    logic [1:0]  code;
    logic [15:0] reads;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd0,  16'd999, 16'd1000,  2'b01, 16'd2},   // R3 settled at once
    '{16'd5,  16'd999, 16'd1000,  2'b01, 16'd8},   // R6 repeated checks
    '{16'd2,  16'd0,   16'd1000,  2'b01, 16'd4},   // R4 fault, settles in extra pair
    '{16'd9,  16'd0,   16'd1000,  2'b10, 16'd4},   // R5 fault, still toggling
    '{16'd4,  16'd2,   16'd1000,  2'b01, 16'd6},   // R4 fault on second check
    '{16'd9,  16'd2,   16'd1000,  2'b10, 16'd6},   // R5 fault on second check
    '{16'd99, 16'd999, 16'd0,     2'b11, 16'd0},   // R7 zero budget
    '{16'd99, 16'd999, 16'd3,     2'b11, 16'd2},   // R7 short budget
    '{16'd40, 16'd999, 16'hFFFF,  2'b01, 16'd42}   // R8 unlimited budget
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startReq = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [TW-1:0] startLimit = '0;
  logic          readReq;
  logic [AW-1:0] readAddr;
  logic          readValid = 1'b0;
  logic [DW-1:0] readData = '0;
  logic          resultValid;
  logic [1:0]    resultCode;

  int checks = 0;
  int errors = 0;

  // flash model state
  logic          newRun = 1'b0;
  int            modToggles = 0;
  int            modFaultAt = 0;
  logic [AW-1:0] expAddr = '0;
  int            rdCnt = 0;
  int            addrErr = 0;

  always #4 clk = ~clk;

  nor_busy_poller #(.AW(AW), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startAddr(startAddr),
    .startLimit(startLimit), .readReq(readReq), .readAddr(readAddr),
    .readValid(readValid), .readData(readData),
    .resultValid(resultValid), .resultCode(resultCode)
  );

  function automatic logic [DW-1:0] flashWord(int idx);
    logic [DW-1:0] w;
    w = 16'h1234 & ~16'h0060;
    w[6] = (idx < modToggles) ? idx[0] : modToggles[0];
    w[5] = (idx >= modFaultAt);
    return w;
  endfunction

  always @(posedge clk) begin
    if (newRun) rdCnt = 0;
    if (!rst_n) begin
      readValid <= 1'b0;
    end else if (readReq && !readValid) begin
      readValid <= 1'b1;
      readData  <= flashWord(rdCnt);
      if (readAddr != expAddr) addrErr = addrErr + 1;
      rdCnt = rdCnt + 1;
    end else begin
      readValid <= 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(input int tog, input int flt, input logic [TW-1:0] lim,
                        input logic [AW-1:0] addr);
    @(negedge clk);
    modToggles = tog;
    modFaultAt = flt;
    expAddr    = addr;
    startAddr  = addr;
    startLimit = lim;
    startReq   = 1'b1;
    newRun     = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    newRun   = 1'b0;
  endtask

  task automatic waitResult(output int code, output bit seen);
    seen = 0;
    code = 0;
    for (int i = 0; i < 5000; i++) begin
      if (resultValid) begin
        seen = 1;
        code = int'(resultCode);
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int  code;
    bit  seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 readReq", int'(readReq), 0);
    check("R1 resultValid", int'(resultValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(readReq | resultValid), 0);

    for (int v = 0; v < NV; v++) begin
      launch(int'(VECS[v].toggles), int'(VECS[v].faultAt), VECS[v].limit,
             AW'(24'h01_0000 + v * 24'h40));
      waitResult(code, seen);
      check($sformatf("R9 result seen vec%0d", v), int'(seen), 1);
      check($sformatf("R3-code vec%0d", v), code, int'(VECS[v].code));
      check($sformatf("R2 read count vec%0d", v), rdCnt, int'(VECS[v].reads));
      @(negedge clk);
      check($sformatf("R9 pulse width vec%0d", v), int'(resultValid), 0);
    end

    // R10: a start mid-poll with a zero budget and new address is ignored
    launch(20, 999, 16'd1000, 24'h00_ABCD);
    repeat (5) @(negedge clk);
    startReq   = 1'b1;
    startAddr  = 24'h00_1111;
    startLimit = 16'd0;
    @(negedge clk);
    startReq = 1'b0;
    waitResult(code, seen);
    check("R10 result code", code, 1);
    check("R10 read count", rdCnt, 22);
    @(negedge clk);
    check("R10 no second result", int'(resultValid), 0);

    // R2 every read used the start address
    check("R2 address mismatches", addrErr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule